// File: doc/BRIEF.md
# Triggered Ring-Buffer Sample Writer

This block is a single-channel transfer engine that moves converter results into a ring buffer in memory. Each pulse on the conversion-complete input makes it read one element from a fixed source register address. It then writes that element to the next slot of a buffer. The buffer starts at a programmable base and holds a programmable number of elements.

Once the last slot is written, the engine returns to the base on its own and keeps going, so the oldest samples are overwritten. It sets a sticky pass-complete flag at every wrap, which can drive an interrupt. The live write index can be read back, so software can always locate the newest sample.

Configuration uses a four-entry register port with writes and combinational reads. The source is read over a one-cycle read strobe. Memory writes use a valid/ready handshake.

Top module: `ringcap_dma`

## Requirements
- R1: After reset, `src_rd`, `mem_valid` and `irq` are low, and every register reads zero. Register indices are 0 control, 1 base, 2 length and 3 status.
- R2: A `trig` pulse accepted while idle and enabled raises `src_rd` for exactly one cycle, on the cycle after the pulse. `src_addr` equals the `SRC_ADDR` parameter at all times.
- R3: Two cycles after an accepted trigger, `mem_valid` rises. `mem_data` then carries the value `src_data` had during the read cycle. `mem_addr` equals the base register (index 1) plus the write index times `DATA_W/8`.
- R4: While `mem_valid` is high and `mem_ready` is low, the request is held with `mem_addr` and `mem_data` unchanged. The write index moves only on the cycle the write is accepted. The index is readable in status bits [31:16].
- R5: After the write at index LEN-1 is accepted, the index returns to 0 and later writes overwrite the oldest slots from the base. LEN is register index 2.
- R6: Each wrap sets the pass-complete flag, status bit 0. Writing 1 to that bit clears it, and a wrap in the same cycle wins over the clear.
- R7: `irq` is high exactly while the pass-complete flag is set and interrupt enable (control bit 1) is 1.
- R8: A trigger that arrives while a transfer is still in progress is dropped: it causes no extra read or write. It sets the sticky overrun flag, status bit 1, which is cleared by writing 1 to it.
- R9: Triggers are ignored while the enable bit (control bit 0) is 0. Clearing enable lets an in-flight write finish, and the write index then returns to 0.
- R10: A buffer of 800 byte elements is filled and wrapped correctly. The flag rises only after the 800th write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | CFG_W | Register write data |
| cfg_rdata | output | CFG_W | Register read data (combinational) |
| trig | input | 1 | Conversion-complete pulse |
| src_rd | output | 1 | Source register read strobe |
| src_addr | output | ADDR_W | Fixed source register address |
| src_data | input | DATA_W | Source read data, valid with `src_rd` |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| irq | output | 1 | Pass-complete interrupt |

## Verification
A table of samples is pushed through a five-slot buffer with a different write back-pressure for each sample. Zero-stall entries show that acceptance alone moves the index. Multi-cycle stalls show that the request is held steady. Running past the fifth entry checks the wrap point and that the memory image has old slots overwritten.

Directed patterns cover the rest:
- a back-to-back trigger, to separate a dropped trigger from a second transfer;
- triggers while disabled, and a disable during a stalled write;
- a masked wrap, to separate the flag from the interrupt;
- a full 800-element pass, to check the wrap at large lengths.

// File: rtl/ringcap_pkg.sv
package ringcap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_WRITE = 2'd2
   } xfer_st_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_BASE = 2'd1;
   localparam logic [1:0] REG_LEN  = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_IE_BIT  = 1;
   localparam int STAT_DONE_BIT = 0;
   localparam int STAT_OVR_BIT  = 1;
   localparam int STAT_IDX_LSB  = 16;
endpackage

// File: rtl/ringcap_regs.sv
module ringcap_regs
   import ringcap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16,
   parameter int CFG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wrap_evt,
   input  logic              ovr_evt,
   output logic              en,
   output logic              irq_en,
   output logic [ADDR_W-1:0] base,
   output logic [IDX_W-1:0]  len,
   output logic              irq
);
   generate
      if (ADDR_W > CFG_W) begin : g_bad_addr
         $error("ringcap_regs: ADDR_W must not exceed CFG_W");
      end
      if (IDX_W + STAT_IDX_LSB > CFG_W) begin : g_bad_idx
         $error("ringcap_regs: IDX_W does not fit the status word");
      end
   endgenerate

   logic done_q, ovr_q;
   logic wr_ctrl, wr_base, wr_len, wr_stat;

   assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
   assign wr_base = cfg_we && (cfg_addr == REG_BASE);
   assign wr_len  = cfg_we && (cfg_addr == REG_LEN);
   assign wr_stat = cfg_we && (cfg_addr == REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         irq_en <= 1'b0;
         base   <= '0;
         len    <= '0;
      end else begin
         if (wr_ctrl) begin
            en     <= cfg_wdata[CTRL_EN_BIT];
            irq_en <= cfg_wdata[CTRL_IE_BIT];
         end
         if (wr_base) base <= cfg_wdata[ADDR_W-1:0];
         if (wr_len)  len  <= cfg_wdata[IDX_W-1:0];
      end
   end

   // sticky flags: a new event in the same cycle beats a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         done_q <= wrap_evt | (done_q & ~(wr_stat & cfg_wdata[STAT_DONE_BIT]));
         ovr_q  <= ovr_evt  | (ovr_q  & ~(wr_stat & cfg_wdata[STAT_OVR_BIT]));
      end
   end

   assign irq = done_q & irq_en;

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_addr)
         REG_CTRL: begin
            cfg_rdata[CTRL_EN_BIT] = en;
            cfg_rdata[CTRL_IE_BIT] = irq_en;
         end
         REG_BASE: cfg_rdata[ADDR_W-1:0] = base;
         REG_LEN:  cfg_rdata[IDX_W-1:0]  = len;
         REG_STAT: begin
            cfg_rdata[STAT_DONE_BIT] = done_q;
            cfg_rdata[STAT_OVR_BIT]  = ovr_q;
            cfg_rdata[STAT_IDX_LSB +: IDX_W] = idx;
         end
         default: cfg_rdata = '0;
      endcase
   end

   a_r6_wrap_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> done_q);
   a_r6_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && cfg_wdata[STAT_DONE_BIT] && !wrap_evt) |=> !done_q);
   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> ovr_q);
endmodule

// File: rtl/ringcap_seq.sv
module ringcap_seq
   import ringcap_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              trig,
   output logic              src_rd,
   input  logic [DATA_W-1:0] src_data,
   output logic              mem_valid,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ready,
   output logic              accept,
   output logic              ovr_evt,
   output logic              idle
);
   xfer_st_e st_q, st_d;
   logic [DATA_W-1:0] hold_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (trig && en) st_d = ST_FETCH;
         ST_FETCH: st_d = ST_WRITE;
         ST_WRITE: if (mem_ready) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hold_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_FETCH) hold_q <= src_data;
      end
   end

   assign idle      = (st_q == ST_IDLE);
   assign src_rd    = (st_q == ST_FETCH);
   assign mem_valid = (st_q == ST_WRITE);
   assign mem_data  = hold_q;
   assign accept    = mem_valid && mem_ready;
   assign ovr_evt   = trig && en && !idle;

   a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd |=> !src_rd);
   a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd |=> (mem_valid && mem_data == $past(src_data)));
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !idle) |=> !src_rd);
endmodule

// File: rtl/ringcap_ptr.sv
module ringcap_ptr #(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 16,
   parameter int ELEM_BYTES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              idle,
   input  logic              accept,
   input  logic [IDX_W-1:0]  len,
   input  logic [ADDR_W-1:0] base,
   output logic [IDX_W-1:0]  idx,
   output logic              wrap_evt,
   output logic [ADDR_W-1:0] mem_addr
);
   localparam bit POW2 = ((ELEM_BYTES & (ELEM_BYTES - 1)) == 0);
   localparam int STEP_SH = $clog2(ELEM_BYTES);

   generate
      if (ELEM_BYTES < 1) begin : g_bad_elem
         $error("ringcap_ptr: ELEM_BYTES must be at least 1");
      end
   endgenerate

   logic [IDX_W:0]    nxt;
   logic              last;
   logic [ADDR_W-1:0] idx_ext, offset;

   assign nxt  = {1'b0, idx} + 1'b1;
   assign last = (nxt >= {1'b0, len});
   assign wrap_evt = accept && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (accept) begin
         idx <= last ? '0 : nxt[IDX_W-1:0];
      end else if (!en && idle) begin
         idx <= '0;
      end
   end

   assign idx_ext = ADDR_W'(idx);

   generate
      if (POW2) begin : g_shift
         assign offset = idx_ext << STEP_SH;
      end else begin : g_mult
         assign offset = idx_ext * ADDR_W'(ELEM_BYTES);
      end
   endgenerate

   assign mem_addr = base + offset;

   a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> (idx == '0));
   a_r4_idx_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && en) |=> $stable(idx));
   a_r9_idle_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && idle) |=> (idx == '0));
endmodule

// File: rtl/ringcap_dma.sv
module ringcap_dma
   import ringcap_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          DATA_W   = 8,
   parameter int          IDX_W    = 16,
   parameter int          CFG_W    = 32,
   parameter logic [31:0] SRC_ADDR = 32'h4001_0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              trig,
   output logic              src_rd,
   output logic [ADDR_W-1:0] src_addr,
   input  logic [DATA_W-1:0] src_data,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ready,
   output logic              irq
);
   localparam int ELEM_BYTES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
         $error("ringcap_dma: DATA_W must be a whole number of bytes");
      end
      if (IDX_W < 10) begin : g_small_idx
         $error("ringcap_dma: IDX_W too small for an 800-element ring");
      end
   endgenerate

   logic              en, irq_en, accept, ovr_evt, idle, wrap_evt;
   logic [ADDR_W-1:0] base;
   logic [IDX_W-1:0]  len, idx;

   assign src_addr = ADDR_W'(SRC_ADDR);

   ringcap_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CFG_W(CFG_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .idx(idx), .wrap_evt(wrap_evt), .ovr_evt(ovr_evt),
      .en(en), .irq_en(irq_en), .base(base), .len(len), .irq(irq)
   );

   ringcap_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .trig(trig),
      .src_rd(src_rd), .src_data(src_data),
      .mem_valid(mem_valid), .mem_data(mem_data), .mem_ready(mem_ready),
      .accept(accept), .ovr_evt(ovr_evt), .idle(idle)
   );

   ringcap_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ELEM_BYTES(ELEM_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .en(en), .idle(idle), .accept(accept),
      .len(len), .base(base), .idx(idx), .wrap_evt(wrap_evt),
      .mem_addr(mem_addr)
   );

   a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_data)));
   a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en);
   a_r9_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !en && !src_rd && !mem_valid) |=> !src_rd);
endmodule

// File: tb/sim_ringcap_dma.sv
`timescale 1ns/1ps
module sim_ringcap_dma;
   localparam logic [31:0] SRC = 32'h4001_0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        trig = 1'b0;
   logic        src_rd;
   logic [31:0] src_addr;
   logic [7:0]  src_data = '0;
   logic        mem_valid;
   logic [31:0] mem_addr;
   logic [7:0]  mem_data;
   logic        mem_ready = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   bit finished = 0;
   logic [31:0] tb_base = '0;
   logic [7:0]  mem_model [0:1023];

   always #4 clk = ~clk;

   ringcap_dma #(.SRC_ADDR(SRC)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
      .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
      .mem_ready(mem_ready), .irq(irq)
   );

   always @(posedge clk) begin
      if (mem_valid && mem_ready) begin
         wr_cnt <= wr_cnt + 1;
         if (mem_addr - tb_base < 32'd1024)
            mem_model[10'(mem_addr - tb_base)] <= mem_data;
      end
   end

   // stall pattern [11:8], sample [7:0]
   localparam logic [11:0] VEC [0:7] = '{
      12'h0A5, 12'h23C, 12'h000, 12'h1FF, 12'h05A, 12'h381, 12'h07E, 12'h111
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic do_xfer(input logic [7:0] d, input int stall, input logic [31:0] exp_addr);
      mem_ready = 1'b0; src_data = d; trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      check("R2 src_rd", {31'd0, src_rd}, 32'd1);
      check("R2 src_addr", src_addr, SRC);
      @(negedge clk);
      src_data = ~d;
      check("R3 mem_valid", {31'd0, mem_valid}, 32'd1);
      check("R3 mem_addr", mem_addr, exp_addr);
      check("R3 mem_data", {24'd0, mem_data}, {24'd0, d});
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         check("R4 held valid", {31'd0, mem_valid}, 32'd1);
         check("R4 held addr", mem_addr, exp_addr);
         check("R4 held data", {24'd0, mem_data}, {24'd0, d});
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      check("R4 released", {31'd0, mem_valid}, 32'd0);
   endtask

   task automatic xfer_fast(input logic [7:0] d);
      src_data = d; trig = 1'b1; mem_ready = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int k;
      bit done_exp;
      int snap;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 src_rd", {31'd0, src_rd}, 32'd0);
      check("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      for (int r = 0; r < 4; r++) begin
         cfg_read(2'(r), rd);
         check("R1 register", rd, 32'd0);
      end

      tb_base = 32'h2000_0100;
      cfg_write(2'd1, tb_base);
      cfg_write(2'd2, 32'd5);
      cfg_write(2'd0, 32'h3);

      // table walk: R3 R4 R5 R7
      k = 0; done_exp = 0;
      for (int v = 0; v < 8; v++) begin
         do_xfer(VEC[v][7:0], int'(VEC[v][11:8]), tb_base + 32'(k));
         if (k == 4) done_exp = 1;
         k = (k + 1) % 5;
         cfg_read(2'd3, rd);
         check("R4 index", {16'd0, rd[31:16]}, 32'(k));
         check("R7 irq follows flag", {31'd0, irq}, {31'd0, done_exp});
      end
      // R5 ring overwrite image
      check("R5 slot0", {24'd0, mem_model[0]}, 32'h81);
      check("R5 slot1", {24'd0, mem_model[1]}, 32'h7E);
      check("R5 slot2", {24'd0, mem_model[2]}, 32'h11);
      check("R5 slot3", {24'd0, mem_model[3]}, 32'hFF);
      check("R5 slot4", {24'd0, mem_model[4]}, 32'h5A);

      // R6 write-1-to-clear, writing 0 keeps it
      cfg_write(2'd3, 32'h0);
      check("R6 zero write keeps", {31'd0, irq}, 32'd1);
      cfg_write(2'd3, 32'h1);
      check("R6 cleared", {31'd0, irq}, 32'd0);

      // R7 masked wrap: index is 3, two more wrap
      cfg_write(2'd0, 32'h1);
      do_xfer(8'h21, 0, tb_base + 32'd3);
      do_xfer(8'h22, 0, tb_base + 32'd4);
      check("R7 masked irq", {31'd0, irq}, 32'd0);
      cfg_read(2'd3, rd);
      check("R7 flag set under mask", {31'd0, rd[0]}, 32'd1);
      cfg_write(2'd0, 32'h3);
      check("R7 unmasked irq", {31'd0, irq}, 32'd1);
      cfg_write(2'd3, 32'h1);

      // R8 overrun: trigger held two cycles
      snap = wr_cnt;
      src_data = 8'h44; mem_ready = 1'b1; trig = 1'b1;
      @(negedge clk);
      @(negedge clk);
      trig = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R8 one write only", 32'(wr_cnt - snap), 32'd1);
      cfg_read(2'd3, rd);
      check("R8 overrun flag", {31'd0, rd[1]}, 32'd1);
      check("R8 index once", {16'd0, rd[31:16]}, 32'd1);
      cfg_write(2'd3, 32'h2);
      cfg_read(2'd3, rd);
      check("R8 overrun cleared", {31'd0, rd[1]}, 32'd0);

      // R9 disable: index back to 0, triggers ignored
      cfg_write(2'd0, 32'h0);
      @(negedge clk);
      cfg_read(2'd3, rd);
      check("R9 index reset", {16'd0, rd[31:16]}, 32'd0);
      snap = wr_cnt;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      check("R9 no read when off", {31'd0, src_rd}, 32'd0);
      repeat (3) @(negedge clk);
      check("R9 no write when off", 32'(wr_cnt - snap), 32'd0);
      cfg_read(2'd3, rd);
      check("R9 no overrun when off", {31'd0, rd[1]}, 32'd0);

      // R9 disable during a stalled write
      cfg_write(2'd0, 32'h1);
      snap = wr_cnt;
      mem_ready = 1'b0; src_data = 8'h66; trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      @(negedge clk);
      cfg_write(2'd0, 32'h0);
      check("R9 in-flight kept", {31'd0, mem_valid}, 32'd1);
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      @(negedge clk);
      check("R9 in-flight finished", 32'(wr_cnt - snap), 32'd1);
      check("R9 in-flight data", {24'd0, mem_model[0]}, 32'h66);
      cfg_read(2'd3, rd);
      check("R9 index after stop", {16'd0, rd[31:16]}, 32'd0);

      // R10 800-element ring
      tb_base = 32'h3000_0000;
      cfg_write(2'd1, tb_base);
      cfg_write(2'd2, 32'd800);
      cfg_write(2'd3, 32'h3);
      cfg_write(2'd0, 32'h3);
      for (int i = 0; i < 799; i++) xfer_fast(8'(i));
      check("R10 no irq before end", {31'd0, irq}, 32'd0);
      cfg_read(2'd3, rd);
      check("R10 index 799", {16'd0, rd[31:16]}, 32'd799);
      xfer_fast(8'(799));
      check("R10 irq at end", {31'd0, irq}, 32'd1);
      cfg_read(2'd3, rd);
      check("R10 index wraps", {16'd0, rd[31:16]}, 32'd0);
      check("R10 first slot", {24'd0, mem_model[0]}, 32'h00);
      check("R10 last slot", {24'd0, mem_model[799]}, 32'(8'(799)));
      xfer_fast(8'hC3);
      check("R10 overwrite oldest", {24'd0, mem_model[0]}, 32'hC3);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule